// File: doc/BRIEF.md
# Marked Replay Read Pointer

This block is the read-side pointer manager of a FIFO that can replay data. It holds a read pointer and a mark pointer for each of two queues. When the mark strobe is high during a valid read, the address being read becomes that queue's replay point. A retransmit pulse rewinds the read pointer to that point, so words that were already read are delivered again without being written a second time. Reading then continues past the replayed words and into any words written after the rewind.

The storage array and the write side are outside this block. The write pointers come in as inputs. The block computes the empty and full status of each queue from the pointer distances. Full is measured from the mark rather than from the read pointer. This stops the writer from overwriting anything that may still be replayed.

A mode input selects between two configurations. In single-queue mode, queue 0 spans the whole array. In two-queue mode, each queue owns one half of the array, and the read queue select chooses which queue a read, mark or retransmit acts on.

Top module: `mark_rexmit_rdptr`

## Requirements
- R1: After a synchronous reset, both read pointers and both mark pointers are 0. With both write pointers at 0, `empty_vec` is 2'b11 and `full_vec` is 2'b00.
- R2: A valid read happens when `rd_en` is high, the selected queue is not empty and `rexmit` is low. It raises `rd_fire` in that cycle and advances that queue's read pointer by one at the clock edge. A read request on an empty queue changes nothing.
- R3: When `mark` is high during a valid read, the queue's mark pointer takes the read pointer value of that cycle. `mark` without a valid read leaves the mark unchanged.
- R4: When `rexmit` is high, the selected queue's read pointer is loaded with its mark pointer at the clock edge. No read is performed in that cycle, even if `rd_en` is high.
- R5: In two-queue mode (`mode_dual`=1), a read, mark or retransmit acts only on the queue given by `rq_sel`. The other queue's pointers are unchanged.
- R6: In single-queue mode (`mode_dual`=0), `rq_sel` is ignored and every operation acts on queue 0.
- R7: `empty_vec[q]` is high exactly when queue q's read pointer equals its write pointer. It is re-derived in the cycle after a retransmit.
- R8: `full_vec[q]` is high exactly when the write pointer minus the mark pointer, taken modulo 2^(AW+1), equals the queue depth. The depth is TOTAL_DEPTH in single-queue mode and TOTAL_DEPTH/2 in two-queue mode.
- R9: After a retransmit, successive valid reads walk forward until the read pointer reaches the write pointer. This includes words written after the retransmit.
- R10: `rd_addr` is the physical address of the selected queue's read pointer. In single-queue mode it is the pointer's low AW bits. In two-queue mode it is {queue index, the pointer's low AW-1 bits}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_dual | input | 1 | 1 = two queues of half depth, 0 = one queue |
| rd_en | input | 1 | Read request |
| mark | input | 1 | Record the location read in this cycle as the replay point |
| rexmit | input | 1 | Rewind the selected read pointer to its mark |
| rq_sel | input | 1 | Queue chosen for read, mark and retransmit (two-queue mode) |
| wr_ptr_vec | input | 2*(AW+1) | Write pointers, queue 0 in the low slice |
| rd_ptr_vec | output | 2*(AW+1) | Read pointers, queue 0 in the low slice |
| empty_vec | output | 2 | Per-queue empty status |
| full_vec | output | 2 | Per-queue full status, measured from the mark |
| rd_addr | output | AW | Physical array address of the selected read pointer |
| rd_fire | output | 1 | A valid read happens in this cycle |

## Verification
The assertions assume that each write pointer stays between its queue's mark and mark plus the queue depth, so the writer never passes full. They also assume that `mode_dual` changes only while reset is held. The bench writer stores a word only when its own model says the queue is not full. It switches modes only inside its reset task, which keeps the stimulus within these limits. Every read is also checked against a storage array in the bench, keyed by `rd_addr`. This confirms that replayed and newly written words come back in order.

// File: rtl/mrk_pkg.sv
package mrk_pkg;

    localparam int NUM_Q = 2;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_DUAL   = 1'b1
    } q_mode_e;

    // per-queue operation granted by the decoder for one cycle
    typedef struct packed {
        logic rd;      // valid read of this queue
        logic mark;    // record current read location
        logic rexmit;  // reload read pointer from mark
    } q_op_t;

    function automatic logic eff_queue(input q_mode_e mode, input logic sel);
        return (mode == MODE_DUAL) ? sel : 1'b0;
    endfunction

endpackage

// File: rtl/mrk_req_decode.sv
module mrk_req_decode
    import mrk_pkg::*;
(
    input  logic                 mode_dual,
    input  logic                 rd_en,
    input  logic                 mark,
    input  logic                 rexmit,
    input  logic                 rq_sel,
    input  logic [NUM_Q-1:0]     empty_vec,
    output logic                 q_idx,
    output q_op_t [NUM_Q-1:0]    ops
);

    q_mode_e mode;
    logic    read_ok;

    always_comb begin
        mode    = q_mode_e'(mode_dual);
        q_idx   = eff_queue(mode, rq_sel);
        read_ok = rd_en && !rexmit && !empty_vec[q_idx];
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_op
        logic hit;
        assign hit            = (q_idx == 1'(q));
        assign ops[q].rd      = hit && read_ok;
        assign ops[q].mark    = hit && read_ok && mark;
        assign ops[q].rexmit  = hit && rexmit;
    end

endmodule

// File: rtl/mrk_queue_ptr.sv
module mrk_queue_ptr
    import mrk_pkg::*;
#(
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  q_op_t            op,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] mark_ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr   <= '0;
            mark_ptr <= '0;
        end else begin
            if (op.rexmit)
                rd_ptr <= mark_ptr;
            else if (op.rd)
                rd_ptr <= rd_ptr + PTR_W'(1);
            if (op.rd && op.mark)
                mark_ptr <= rd_ptr;
        end
    end

    assert_read_step_R2: assert property (@(posedge clk) disable iff (rst)
        (op.rd && !op.rexmit) |=> rd_ptr == $past(rd_ptr) + PTR_W'(1));

    assert_mark_take_R3: assert property (@(posedge clk) disable iff (rst)
        (op.rd && op.mark) |=> mark_ptr == $past(rd_ptr));

    assert_mark_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(op.rd && op.mark) |=> $stable(mark_ptr));

    assert_rexmit_load_R4: assert property (@(posedge clk) disable iff (rst)
        op.rexmit |=> rd_ptr == $past(mark_ptr));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!op.rd && !op.rexmit) |=> $stable(rd_ptr));

endmodule

// File: rtl/mrk_flag_calc.sv
module mrk_flag_calc #(
    parameter int TOTAL_DEPTH = 16,
    parameter int PTR_W       = 5
) (
    input  logic             mode_dual,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic [PTR_W-1:0] mark_ptr,
    input  logic [PTR_W-1:0] wr_ptr,
    output logic             empty,
    output logic             full
);

    localparam logic [PTR_W-1:0] DEPTH_ALL  = PTR_W'(TOTAL_DEPTH);
    localparam logic [PTR_W-1:0] DEPTH_HALF = PTR_W'(TOTAL_DEPTH / 2);

    logic [PTR_W-1:0] live;
    logic [PTR_W-1:0] depth;

    always_comb begin
        depth = mode_dual ? DEPTH_HALF : DEPTH_ALL;
        live  = wr_ptr - mark_ptr;   // words held from the mark onward
        empty = (rd_ptr == wr_ptr);
        full  = (live == depth);
    end

endmodule

// File: rtl/mark_rexmit_rdptr.sv
module mark_rexmit_rdptr
    import mrk_pkg::*;
#(
    parameter  int TOTAL_DEPTH = 16,
    localparam int AW          = $clog2(TOTAL_DEPTH),
    localparam int PTR_W       = AW + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mode_dual,
    input  logic                   rd_en,
    input  logic                   mark,
    input  logic                   rexmit,
    input  logic                   rq_sel,
    input  logic [NUM_Q*PTR_W-1:0] wr_ptr_vec,
    output logic [NUM_Q*PTR_W-1:0] rd_ptr_vec,
    output logic [NUM_Q-1:0]       empty_vec,
    output logic [NUM_Q-1:0]       full_vec,
    output logic [AW-1:0]          rd_addr,
    output logic                   rd_fire
);

    localparam int QAW = AW - 1;

    q_op_t [NUM_Q-1:0] ops;
    logic              q_idx;
    logic [PTR_W-1:0]  rd_a   [NUM_Q];
    logic [PTR_W-1:0]  mark_a [NUM_Q];
    logic [PTR_W-1:0]  wr_a   [NUM_Q];
    logic [NUM_Q-1:0]  rd_bits;

    mrk_req_decode u_dec (
        .mode_dual (mode_dual),
        .rd_en     (rd_en),
        .mark      (mark),
        .rexmit    (rexmit),
        .rq_sel    (rq_sel),
        .empty_vec (empty_vec),
        .q_idx     (q_idx),
        .ops       (ops)
    );

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        assign wr_a[q]                    = wr_ptr_vec[q*PTR_W +: PTR_W];
        assign rd_ptr_vec[q*PTR_W +: PTR_W] = rd_a[q];
        assign rd_bits[q]                 = ops[q].rd;

        mrk_queue_ptr #(.PTR_W(PTR_W)) u_ptr (
            .clk      (clk),
            .rst      (rst),
            .op       (ops[q]),
            .rd_ptr   (rd_a[q]),
            .mark_ptr (mark_a[q])
        );

        mrk_flag_calc #(.TOTAL_DEPTH(TOTAL_DEPTH), .PTR_W(PTR_W)) u_flag (
            .mode_dual (mode_dual),
            .rd_ptr    (rd_a[q]),
            .mark_ptr  (mark_a[q]),
            .wr_ptr    (wr_a[q]),
            .empty     (empty_vec[q]),
            .full      (full_vec[q])
        );
    end

    always_comb begin
        rd_fire = |rd_bits;
        if (mode_dual)
            rd_addr = {q_idx, rd_a[q_idx][QAW-1:0]};
        else
            rd_addr = rd_a[0][AW-1:0];
    end

    assert_one_queue_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_bits));

    assert_single_q0_R6: assert property (@(posedge clk) disable iff (rst)
        !mode_dual |-> (!ops[1].rd && !ops[1].rexmit));

    assert_no_empty_read_R7: assert property (@(posedge clk) disable iff (rst)
        rd_fire |-> (rd_a[q_idx] != wr_a[q_idx]));

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (rd_a[0] == '0 && rd_a[1] == '0 && mark_a[0] == '0 && mark_a[1] == '0));

endmodule

// File: tb/mark_rexmit_rdptr_tb_top.sv
`timescale 1ns/1ps
module mark_rexmit_rdptr_tb_top;

    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int PTR_W = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, mode_dual, rd_en, mark, rexmit, rq_sel;
    logic [PTR_W-1:0]   wr_p [2];
    logic [2*PTR_W-1:0] wr_vec, rd_vec;
    logic [1:0]         empty_vec, full_vec;
    logic [AW-1:0]      rd_addr;
    logic               rd_fire;

    assign wr_vec = {wr_p[1], wr_p[0]};

    mark_rexmit_rdptr #(.TOTAL_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .mode_dual(mode_dual), .rd_en(rd_en),
        .mark(mark), .rexmit(rexmit), .rq_sel(rq_sel), .wr_ptr_vec(wr_vec),
        .rd_ptr_vec(rd_vec), .empty_vec(empty_vec), .full_vec(full_vec),
        .rd_addr(rd_addr), .rd_fire(rd_fire)
    );

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] m_rd [2];
    logic [PTR_W-1:0] m_mark [2];
    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int qdepth();
        return mode_dual ? DEPTH / 2 : DEPTH;
    endfunction

    function automatic int phys(input int q, input logic [PTR_W-1:0] p);
        return mode_dual ? q * (DEPTH / 2) + int'(p[AW-2:0]) : int'(p[AW-1:0]);
    endfunction

    function automatic bit m_empty(input int q);
        return m_rd[q] == wr_p[q];
    endfunction

    function automatic bit m_full(input int q);
        logic [PTR_W-1:0] d;
        d = wr_p[q] - m_mark[q];
        return int'(d) == qdepth();
    endfunction

    function automatic int dut_rd(input int q);
        return int'(rd_vec[q*PTR_W +: PTR_W]);
    endfunction

    task automatic do_reset(input bit dual);
        @(negedge clk);
        rst = 1; mode_dual = dual; rd_en = 0; mark = 0; rexmit = 0; rq_sel = 0;
        wr_p[0] = '0; wr_p[1] = '0;
        for (int i = 0; i < 2; i++) begin m_rd[i] = '0; m_mark[i] = '0; end
        @(negedge clk); @(negedge clk);
        rst = 0;
    endtask

    task automatic push(input int q, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!m_full(q)) begin
                mem[phys(q, wr_p[q])] = 8'((q << 7) | int'(wr_p[q]));
                wr_p[q] = wr_p[q] + PTR_W'(1);
            end
            #1;
            chk("R8", "full flag", int'(full_vec[q]), int'(m_full(q)));
        end
    endtask

    task automatic cycle(input bit en, input bit mk, input bit rx, input bit sel, input string tag);
        int  q;
        bit  fire;
        @(negedge clk);
        rd_en = en; mark = mk; rexmit = rx; rq_sel = sel;
        #1;
        q    = mode_dual ? int'(sel) : 0;
        fire = en && !rx && !m_empty(q);
        chk("R2", "rd_fire", int'(rd_fire), int'(fire));
        if (fire) begin
            chk("R10", "rd_addr", int'(rd_addr), phys(q, m_rd[q]));
            chk("R10", "data", int'(mem[rd_addr]), (q << 7) | int'(m_rd[q]));
        end
        if (rx) m_rd[q] = m_mark[q];
        else if (fire) begin
            if (mk) m_mark[q] = m_rd[q];
            m_rd[q] = m_rd[q] + PTR_W'(1);
        end
        @(posedge clk); #1;
        rd_en = 0; mark = 0; rexmit = 0;
        for (int i = 0; i < 2; i++) begin
            chk(tag, "rd_ptr", dut_rd(i), int'(m_rd[i]));
            chk("R7", "empty", int'(empty_vec[i]), int'(m_empty(i)));
            chk("R8", "full", int'(full_vec[i]), int'(m_full(i)));
        end
    endtask

    task automatic t_reset();
        do_reset(0);
        #1;
        chk("R1", "rd_ptr0", dut_rd(0), 0);
        chk("R1", "rd_ptr1", dut_rd(1), 0);
        chk("R1", "empty", int'(empty_vec), 3);
        chk("R1", "full", int'(full_vec), 0);
    endtask

    task automatic t_single();
        do_reset(0);
        push(0, 3);
        cycle(1, 0, 0, 1, "R6");
        chk("R6", "q0 advanced", dut_rd(0), 1);
        chk("R6", "q1 untouched", dut_rd(1), 0);
        cycle(1, 0, 0, 1, "R2");
        cycle(1, 0, 0, 0, "R2");
        cycle(1, 0, 0, 0, "R2");
        chk("R2", "read on empty holds", dut_rd(0), 3);
        chk("R7", "empty after drain", int'(empty_vec[0]), 1);
    endtask

    task automatic t_mark_replay();
        do_reset(0);
        push(0, 4);
        cycle(1, 0, 0, 0, "R2");
        cycle(1, 1, 0, 0, "R3");
        cycle(1, 0, 0, 0, "R2");
        cycle(1, 0, 0, 0, "R2");
        chk("R7", "drained", int'(empty_vec[0]), 1);
        cycle(0, 1, 0, 0, "R3");
        cycle(0, 0, 1, 0, "R4");
        chk("R4", "rewound to mark", dut_rd(0), 1);
        chk("R7", "not empty after replay", int'(empty_vec[0]), 0);
        cycle(1, 0, 1, 0, "R4");
        chk("R4", "rexmit beats read", dut_rd(0), 1);
        cycle(1, 0, 0, 0, "R9");
        push(0, 2);
        for (int i = 0; i < 4; i++) cycle(1, 0, 0, 0, "R9");
        chk("R9", "reached new writes", dut_rd(0), 6);
        chk("R9", "empty at end", int'(empty_vec[0]), 1);
    endtask

    task automatic t_full();
        do_reset(0);
        push(0, 15);
        chk("R8", "not full at 15", int'(full_vec[0]), 0);
        push(0, 2);
        chk("R8", "full at 16", int'(full_vec[0]), 1);
        for (int i = 0; i < 5; i++) cycle(1, 0, 0, 0, "R2");
        chk("R8", "full held by mark 0", int'(full_vec[0]), 1);
        cycle(1, 1, 0, 0, "R3");
        chk("R8", "mark moved frees space", int'(full_vec[0]), 0);
        push(0, 5);
        chk("R8", "full again after 5", int'(full_vec[0]), 1);
        do_reset(1);
        push(1, 8);
        chk("R8", "half queue full", int'(full_vec), 2);
    endtask

    task automatic t_dual();
        do_reset(1);
        push(0, 2);
        push(1, 3);
        cycle(1, 0, 0, 1, "R5");
        chk("R5", "q1 read", dut_rd(1), 1);
        chk("R5", "q0 untouched", dut_rd(0), 0);
        cycle(1, 1, 0, 1, "R3");
        cycle(1, 0, 0, 0, "R5");
        cycle(0, 0, 1, 0, "R5");
        chk("R5", "q0 rewound", dut_rd(0), 0);
        chk("R5", "q1 kept", dut_rd(1), 2);
        cycle(0, 0, 1, 1, "R4");
        chk("R4", "q1 rewound to mark", dut_rd(1), 1);
        cycle(1, 0, 0, 1, "R10");
        cycle(1, 0, 0, 1, "R9");
        chk("R9", "q1 drained", int'(empty_vec[1]), 1);
    endtask

    initial begin
        rst = 1; mode_dual = 0; rd_en = 0; mark = 0; rexmit = 0; rq_sel = 0;
        wr_p[0] = '0; wr_p[1] = '0;
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        t_reset();
        t_single();
        t_mark_replay();
        t_full();
        t_dual();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule